// File: doc/BRIEF.md
# Next-PC sequencer for branches and jumps

This block holds the 32-bit program counter of a simple in-order core and works out its next value every cycle. It takes a small decoded operation code and two register operands. It also takes the 16-bit branch displacement and the 26-bit jump index. From these it picks one of four next values: the sequential address, a PC-relative branch target, a region-local jump target, or a register-supplied address.

All three targets are computed in parallel from PC+4. A compare of the two operands then selects among them. The block also produces the return address and a write request for the link register of a call. It flags a taken control transfer and a misaligned register jump. A stall input freezes the counter and suppresses every indication.

Top module: `npc_unit`

## Requirements
- R1: While rst_ni is low, pc_o equals the RESET_VEC parameter (default 0). It stays there for the first cycle after release.
- R2: With op_i = 0 (sequential) or an unassigned code (6 or 7), the PC advances by 4 at the next clock edge and taken_o is 0.
- R3: With op_i = 1 (branch if equal) and rs_val_i equal to rt_val_i, taken_o is 1 and the next PC is PC+4 plus imm_i sign-extended and multiplied by 4. With unequal operands, the PC advances by 4 and taken_o is 0.
- R4: With op_i = 2 (branch if different), the PC goes to the branch target of R3 with taken_o = 1 when the operands differ. It advances by 4 with taken_o = 0 when they are equal.
- R5: With op_i = 3 (jump), taken_o is 1 and the next PC is bits 31:28 of PC+4, then jidx_i, then two zero bits. A jump from the last word of a 256 MB region therefore lands in the following region.
- R6: With op_i = 4 (jump and link), the PC goes to the R5 target. In the same cycle link_we_o is 1, link_idx_o is 31 and link_o equals PC+4. For every other code, link_we_o is 0.
- R7: With op_i = 5 (register jump) and rs_val_i[1:0] = 0, taken_o is 1 and the next PC equals rs_val_i.
- R8: With op_i = 5 and rs_val_i[1:0] non-zero, align_err_o is 1, taken_o is 0 and the PC keeps its value.
- R9: While stall_i is 1, the PC keeps its value, and taken_o, link_we_o and align_err_o are all 0, whatever op_i is.
- R10: link_o always equals pc_o + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Hold the PC and suppress indications |
| op_i | input | 3 | Decoded control: 0 seq, 1 eq-branch, 2 ne-branch, 3 jump, 4 jump-and-link, 5 register jump |
| rs_val_i | input | 32 | First register operand, also register-jump target |
| rt_val_i | input | 32 | Second register operand |
| imm_i | input | 16 | Branch displacement in words |
| jidx_i | input | 26 | Jump word index within the region |
| pc_o | output | 32 | Current program counter |
| link_o | output | 32 | Return address (PC+4) |
| link_we_o | output | 1 | Link register write request |
| link_idx_o | output | 5 | Link register number |
| taken_o | output | 1 | Control transfer taken this cycle |
| align_err_o | output | 1 | Register-jump target not word aligned |

## Verification
The bench builds the block with its default widths: a 16-bit displacement, a 26-bit jump index, link register 31 and reset vector 0. These defaults put the 256 MB region boundary of jumps within reach, by first using a register jump to 0x0FFFFFFC. They also allow a negative displacement that branches backwards. Random operands are paired with forced equal operands and mostly aligned register targets, so both outcomes of each compare, and both aligned and misaligned register jumps, occur many times.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_SEQ = 3'd0,
    OP_BEQ = 3'd1,
    OP_BNE = 3'd2,
    OP_J   = 3'd3,
    OP_JAL = 3'd4,
    OP_JR  = 3'd5
  } npc_op_e;
endpackage

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned JIDX_W = 26
) (
  input  logic [XLEN-1:0]   pc_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [JIDX_W-1:0] jidx_i,
  output logic [XLEN-1:0]   seq_o,
  output logic [XLEN-1:0]   br_o,
  output logic [XLEN-1:0]   jmp_o
);
  localparam int unsigned SEXT_W = XLEN - IMM_W - 2;
  localparam int unsigned HI_W   = XLEN - JIDX_W - 2;

  logic [XLEN-1:0] disp;

  assign seq_o = pc_i + XLEN'(4);
  assign disp  = {{SEXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
  assign br_o  = seq_o + disp;
  // region bits come from the incremented PC
  assign jmp_o = {seq_o[XLEN-1 -: HI_W], jidx_i, 2'b00};
endmodule

// File: rtl/npc_decide.sv
module npc_decide
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [OP_W-1:0] op_i,
  input  logic            stall_i,
  input  logic [XLEN-1:0] rs_i,
  input  logic [XLEN-1:0] rt_i,
  input  logic [XLEN-1:0] seq_i,
  input  logic [XLEN-1:0] br_i,
  input  logic [XLEN-1:0] jmp_i,
  output logic [XLEN-1:0] next_o,
  output logic            load_o,
  output logic            taken_o,
  output logic            link_we_o,
  output logic            align_err_o
);
  logic same;
  assign same = (rs_i == rt_i);

  always_comb begin
    next_o      = seq_i;
    load_o      = 1'b1;
    taken_o     = 1'b0;
    link_we_o   = 1'b0;
    align_err_o = 1'b0;
    case (op_i)
      OP_BEQ: if (same)  begin next_o = br_i; taken_o = 1'b1; end
      OP_BNE: if (!same) begin next_o = br_i; taken_o = 1'b1; end
      OP_J:   begin next_o = jmp_i; taken_o = 1'b1; end
      OP_JAL: begin next_o = jmp_i; taken_o = 1'b1; link_we_o = 1'b1; end
      OP_JR: begin
        if (rs_i[1:0] != 2'b00) begin
          align_err_o = 1'b1;
          load_o      = 1'b0;
        end else begin
          next_o  = rs_i;
          taken_o = 1'b1;
        end
      end
      default: ;
    endcase
    if (stall_i) begin
      load_o      = 1'b0;
      taken_o     = 1'b0;
      link_we_o   = 1'b0;
      align_err_o = 1'b0;
    end
  end
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
  parameter int unsigned       XLEN      = 32,
  parameter logic [XLEN-1:0]   RESET_VEC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [XLEN-1:0] d_i,
  output logic [XLEN-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RESET_VEC;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned   IMM_W     = 16,
  parameter int unsigned   JIDX_W    = 26,
  parameter int unsigned   RIDX_W    = 5,
  parameter int unsigned   LINK_IDX  = 31,
  parameter logic [31:0]   RESET_VEC = 32'h0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   rt_val_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [JIDX_W-1:0] jidx_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   link_o,
  output logic              link_we_o,
  output logic [RIDX_W-1:0] link_idx_o,
  output logic              taken_o,
  output logic              align_err_o
);
  logic [XLEN-1:0] seq_pc, br_pc, jmp_pc, next_pc;
  logic            load;

  npc_target_gen #(.XLEN(XLEN), .IMM_W(IMM_W), .JIDX_W(JIDX_W)) u_tgt (
    .pc_i   (pc_o),
    .imm_i  (imm_i),
    .jidx_i (jidx_i),
    .seq_o  (seq_pc),
    .br_o   (br_pc),
    .jmp_o  (jmp_pc)
  );

  npc_decide #(.XLEN(XLEN)) u_dec (
    .op_i        (op_i),
    .stall_i     (stall_i),
    .rs_i        (rs_val_i),
    .rt_i        (rt_val_i),
    .seq_i       (seq_pc),
    .br_i        (br_pc),
    .jmp_i       (jmp_pc),
    .next_o      (next_pc),
    .load_o      (load),
    .taken_o     (taken_o),
    .link_we_o   (link_we_o),
    .align_err_o (align_err_o)
  );

  npc_pc_reg #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_pc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (load),
    .d_i    (next_pc),
    .q_o    (pc_o)
  );

  assign link_o     = seq_pc;
  assign link_idx_o = RIDX_W'(LINK_IDX);
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
  import npc_pkg::*;
#(
  parameter int unsigned JIDX_W = 26
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stall_i,
  input logic [OP_W-1:0]   op_i,
  input logic [XLEN-1:0]   rs_val_i,
  input logic [JIDX_W-1:0] jidx_i,
  input logic [XLEN-1:0]   pc_o,
  input logic [XLEN-1:0]   link_o,
  input logic              link_we_o,
  input logic              taken_o,
  input logic              align_err_o
);
  localparam int unsigned HI_W = XLEN - JIDX_W - 2;

  a_r2_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && op_i == OP_SEQ) |=> pc_o == $past(pc_o) + 32'd4);

  a_r6_link_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |=> pc_o == {$past(link_o[XLEN-1 -: HI_W]), $past(jidx_i), 2'b00});

  a_r7_reg_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o && op_i == OP_JR) |=> pc_o == $past(rs_val_i));

  a_r8_misalign_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |=> $stable(pc_o));

  a_r8_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({align_err_o, taken_o}));

  a_r9_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(pc_o));

  a_r9_stall_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !(taken_o || link_we_o || align_err_o));
endmodule

bind npc_unit npc_unit_chk #(.JIDX_W(JIDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stall_i     (stall_i),
  .op_i        (op_i),
  .rs_val_i    (rs_val_i),
  .jidx_i      (jidx_i),
  .pc_o        (pc_o),
  .link_o      (link_o),
  .link_we_o   (link_we_o),
  .taken_o     (taken_o),
  .align_err_o (align_err_o)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        stall_i;
  logic [2:0]  op_i;
  logic [31:0] rs_val_i, rt_val_i;
  logic [15:0] imm_i;
  logic [25:0] jidx_i;
  logic [31:0] pc_o, link_o;
  logic        link_we_o, taken_o, align_err_o;
  logic [4:0]  link_idx_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_pc;

  always #5 clk_i = ~clk_i;

  npc_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .stall_i(stall_i), .op_i(op_i),
    .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .imm_i(imm_i), .jidx_i(jidx_i),
    .pc_o(pc_o), .link_o(link_o), .link_we_o(link_we_o), .link_idx_o(link_idx_o),
    .taken_o(taken_o), .align_err_o(align_err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_taken(logic [2:0] op, logic [31:0] rs, logic [31:0] rt, logic st);
    if (st) return 1'b0;
    case (op)
      3'd1: return rs == rt;
      3'd2: return rs != rt;
      3'd3, 3'd4: return 1'b1;
      3'd5: return rs[1:0] == 2'b00;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] exp_next(logic [31:0] pc, logic [2:0] op, logic [31:0] rs,
                                           logic [31:0] rt, logic [15:0] imm, logic [25:0] ji,
                                           logic st);
    logic [31:0] p4 = pc + 32'd4;
    if (st) return pc;
    if (op == 3'd5 && rs[1:0] != 2'b00) return pc;
    if (!exp_taken(op, rs, rt, st)) return p4;
    case (op)
      3'd1, 3'd2: return p4 + {{14{imm[15]}}, imm, 2'b00};
      3'd3, 3'd4: return {p4[31:28], ji, 2'b00};
      default:    return rs;
    endcase
  endfunction

  function automatic string tag(logic [2:0] op, logic st);
    if (st) return "R9";
    case (op)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7/R8";
      default: return "R2";
    endcase
  endfunction

  // called just after a falling edge
  task automatic step(input logic [2:0] op, input logic [31:0] rs, input logic [31:0] rt,
                      input logic [15:0] imm, input logic [25:0] ji, input logic st);
    logic [31:0] nxt;
    op_i = op; rs_val_i = rs; rt_val_i = rt; imm_i = imm; jidx_i = ji; stall_i = st;
    #1;
    chk(tag(op, st), {31'd0, taken_o}, {31'd0, exp_taken(op, rs, rt, st)});
    chk("R6 link_we", {31'd0, link_we_o}, {31'd0, (op == 3'd4) && !st});
    chk("R8 align_err", {31'd0, align_err_o}, {31'd0, (op == 3'd5) && (rs[1:0] != 0) && !st});
    chk("R10 link", link_o, m_pc + 32'd4);
    nxt = exp_next(m_pc, op, rs, rt, imm, ji, st);
    @(posedge clk_i);
    @(negedge clk_i);
    m_pc = nxt;
    chk({tag(op, st), " pc"}, pc_o, m_pc);
  endtask

  initial begin
    #2_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_ni = 1'b0; stall_i = 1'b0; op_i = 3'd0;
    rs_val_i = '0; rt_val_i = '0; imm_i = '0; jidx_i = '0;
    repeat (2) @(negedge clk_i);
    chk("R1 reset pc", pc_o, 32'h0);
    chk("R1 reset link_we", {31'd0, link_we_o}, 32'd0);
    rst_ni = 1'b1;
    m_pc = 32'h0;
    #1 chk("R1 pc after release", pc_o, 32'h0);

    step(3'd0, 0, 0, 0, 0, 1'b0);                              // R2
    step(3'd7, 0, 0, 0, 0, 1'b0);                              // R2 unassigned code
    step(3'd1, 32'h55, 32'h55, 16'h0010, 0, 1'b0);             // R3 equal
    step(3'd1, 32'h55, 32'h56, 16'h0010, 0, 1'b0);             // R3 unequal
    step(3'd2, 32'h1, 32'h1, 16'hFFFE, 0, 1'b0);               // R4 equal -> no branch
    step(3'd2, 32'h1, 32'h2, 16'hFFFE, 0, 1'b0);               // R4 backward branch
    step(3'd5, 32'h0FFF_FFFC, 0, 0, 0, 1'b0);                  // R7 to region edge
    step(3'd3, 0, 0, 0, 26'h10, 1'b0);                         // R5 crosses region
    chk("R5 region", pc_o, 32'h1000_0040);
    step(3'd4, 0, 0, 0, 26'h3FF_FFFF, 1'b0);                   // R6
    step(3'd5, 32'h0000_0103, 0, 0, 0, 1'b0);                  // R8 misaligned
    step(3'd3, 0, 0, 0, 26'h123, 1'b1);                        // R9 stalled jump
    step(3'd5, 32'h2, 0, 0, 0, 1'b1);                          // R9 stalled misaligned
    chk("R6 link_idx", {27'd0, link_idx_o}, 32'd31);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] rs = $urandom;
      logic [31:0] rt = ($urandom_range(0, 1) == 0) ? rs : $urandom;
      logic [2:0]  op = 3'($urandom_range(0, 7));
      if (op == 3'd5 && $urandom_range(0, 3) != 0) rs[1:0] = 2'b00;
      step(op, rs, rt, 16'($urandom), 26'($urandom), $urandom_range(0, 9) == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule